// File: doc/BRIEF.md
# Memory Interface Reset Requester

This block lives in user logic next to one or more external-memory controllers that share core clocks. A one-cycle trigger asks it to restart those controllers. The block waits until every controller reports that its previous reset has finished. It then drives a clean low-high-low request pulse of configurable width and follows the controllers through their reset sequence. The sequence starts when the combined done indication falls and ends when every done rises again.

While a sequence is under way the block reports busy. It reports complete once the done flags return, and it raises an error if no controller reacts within a bounded time. Calibration outcome is never inferred from the done flags. It is taken from separate pass and fail inputs and shown only once a sequence has completed.

All status inputs are asynchronous to the block clock and pass through two-flop synchronizers. The block's own reset `rst_n` must come from a source that the controllers' core reset does not drive. Otherwise the registers that watch the done flags would be cleared in the middle of the sequence they are watching.

Top module: `memif_rst_requester`

## Requirements
- R1: The request output rises only when the synchronized done flags of all NUM_IF interfaces are high; if any one is low the block holds in its waiting phase with the request low.
- R2: A trigger accepted while idle sets busy on the next clock; busy stays high until the sequence completes or times out.
- R3: The request output is high for exactly max(PULSE_W, 2) consecutive clock cycles per accepted trigger, then returns low; a PULSE_W below 2 behaves as 2.
- R4: After the pulse, any interface's synchronized done flag going low marks the sequence as started. All of them high again ends it: complete goes high and busy goes low on the same clock.
- R5: Each asynchronous input (done, pass, fail) reaches the control logic through a two-flop synchronizer, so a change becomes visible to the state machine on the second rising edge after it.
- R6: A trigger arriving while busy is high is ignored: request timing and busy are unchanged, and a drop flag goes high and stays high until rst_n.
- R7: If the done flags do not fall within TIMEOUT_CYC cycles after the pulse ends, a sticky error flag is set, busy goes low and complete stays low.
- R8: cal_ok is high only while complete is high, every synchronized pass input is 1 and every synchronized fail input is 0. cal_bad is high only while complete is high and any synchronized fail input is 1. Done returning high alone drives neither.
- R9: While rst_n is low at a clock edge, all outputs are 0 after that edge.
- R10: Complete stays high until the next accepted trigger and drops on the clock that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset, independent of the controllers' core reset |
| trigger | input | 1 | One-cycle restart request from user logic |
| done_in | input | NUM_IF | Per-interface reset-done flags, asynchronous |
| cal_pass_in | input | NUM_IF | Per-interface calibration-success status, asynchronous |
| cal_fail_in | input | NUM_IF | Per-interface calibration-failure status, asynchronous |
| req_out | output | 1 | Reset request pulse to the controllers |
| busy | output | 1 | A trigger has been accepted and the sequence has not ended |
| complete | output | 1 | Last sequence finished with all done flags high |
| drop_flag | output | 1 | Sticky: a trigger was ignored because the block was busy |
| timeout_err | output | 1 | Sticky: done flags did not fall in time after the pulse |
| cal_ok | output | 1 | Completed and every interface reports calibration success |
| cal_bad | output | 1 | Completed and at least one interface reports calibration failure |

## Verification
The assertions assume the trigger lasts one cycle and that done flags return high only after they have fallen, as a real controller behaves. They also assume status inputs change no faster than the synchronizer can follow. The stimulus drives every input on the falling clock edge. It holds each done pattern for several cycles and acts as the controller itself: it lowers and raises the done flags in deliberate partial patterns, or never lowers them at all to reach the timeout. Extra triggers are issued only in the middle of a sequence or while the block is idle.

// File: rtl/memif_rr_pkg.sv
// Package: shared state encoding and the pulse-width clamp for the
// memory interface reset requester. Assumes nothing beyond 1800-2017.
package memif_rr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_READY = 3'd1,
        ST_PULSE      = 3'd2,
        ST_WAIT_FALL  = 3'd3,
        ST_WAIT_RISE  = 3'd4
    } rr_state_t;

    // Minimum legal high phase of the request pulse, in clock cycles.
    localparam int MIN_PULSE = 2;

    // Returns the effective pulse width: never below MIN_PULSE.
    function automatic int clamp_width(input int req_w);
        return (req_w < MIN_PULSE) ? MIN_PULSE : req_w;
    endfunction

endpackage

// File: rtl/memif_rr_sync.sv
// Module: memif_rr_sync
// Multi-stage synchronizer for a vector of asynchronous level inputs.
// Assumes each bit is a slow level; bits are not coherent with each other.
// Reset is the block's own rst_n, never the controllers' core reset.
module memif_rr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [WIDTH-1:0] stage_q [DEPTH];

    // First stage: capture the asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_stage
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[DEPTH-1];

endmodule

// File: rtl/memif_rr_pulse.sv
// Module: memif_rr_pulse
// Drives the request pulse for a fixed number of cycles after a one-cycle
// fire strobe. Assumes fire is never given while the pulse is active.
module memif_rr_pulse #(
    parameter int PULSE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req,
    output logic last
);
    import memif_rr_pkg::*;

    localparam int EFF_W = clamp_width(PULSE_W);
    localparam int CW    = (EFF_W > 1) ? $clog2(EFF_W) : 1;
    localparam logic [CW-1:0] LOAD = CW'(EFF_W - 1);

    logic [CW-1:0] cnt_q;
    logic          req_q;

    // Load the width on fire, count down while high, drop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cnt_q <= '0;
        end else if (fire) begin
            req_q <= 1'b1;
            cnt_q <= LOAD;
        end else if (req_q) begin
            if (cnt_q == '0) req_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign req  = req_q;
    assign last = req_q && (cnt_q == '0);

    // R3: once raised, the request is still high on the next cycle.
    assert_pulse_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |=> req_q);

endmodule

// File: rtl/memif_rr_timeout.sv
// Module: memif_rr_timeout
// Counts cycles while run is high and flags expiry on the LIMIT-th one.
// Assumes run drops for at least one cycle between two waiting windows.
module memif_rr_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int LIM = (LIMIT < 1) ? 1 : LIMIT;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] cnt_q;

    // Count while waiting; restart from zero whenever not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/memif_rr_seq.sv
// Module: memif_rr_seq
// Sequencer: accepts triggers, gates on readiness, follows the done flags
// through fall and rise, and keeps the sticky status flags.
// Assumes trigger is a one-cycle strobe and inputs are already synchronous.
module memif_rr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic all_ready,
    input  logic pulse_last,
    input  logic expired,
    output logic fire,
    output logic wait_fall,
    output logic busy,
    output logic complete,
    output logic drop_flag,
    output logic timeout_err
);
    import memif_rr_pkg::*;

    rr_state_t state_q, state_d;
    logic      complete_q, drop_q, err_q;

    // Next-state decode of the request sequence.
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE:       if (trigger) state_d = ST_WAIT_READY;
            ST_WAIT_READY: if (all_ready) begin
                               state_d = ST_PULSE;
                               fire    = 1'b1;
                           end
            ST_PULSE:      if (pulse_last) state_d = ST_WAIT_FALL;
            ST_WAIT_FALL:  if (!all_ready)  state_d = ST_WAIT_RISE;
                           else if (expired) state_d = ST_IDLE;
            ST_WAIT_RISE:  if (all_ready) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Completion flag: set when done rises again, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) complete_q <= 1'b0;
        else if (state_q == ST_IDLE && trigger) complete_q <= 1'b0;
        else if (state_q == ST_WAIT_RISE && all_ready) complete_q <= 1'b1;
    end

    // Sticky flag for triggers that arrive while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= 1'b0;
        else if (trigger && state_q != ST_IDLE) drop_q <= 1'b1;
    end

    // Sticky flag for a sequence that never started.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (state_q == ST_WAIT_FALL && all_ready && expired) err_q <= 1'b1;
    end

    assign wait_fall   = (state_q == ST_WAIT_FALL);
    assign busy        = (state_q != ST_IDLE);
    assign complete    = complete_q;
    assign drop_flag   = drop_q;
    assign timeout_err = err_q;

    // R6: the drop flag never clears without reset.
    assert_drop_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |=> drop_q);
    // R7: an error appears only out of the waiting-for-fall phase.
    assert_timeout_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(state_q == ST_WAIT_FALL));
    // R4: completion and busy are never high together.
    assert_complete_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        complete_q |-> !busy);

endmodule

// File: rtl/memif_rst_requester.sv
// Module: memif_rst_requester (top)
// Issues a reset request to NUM_IF memory controllers sharing core clocks,
// tracks their done flags and reports completion and calibration status.
// Assumes rst_n is not derived from the controllers' core reset.
module memif_rst_requester #(
    parameter int NUM_IF      = 2,
    parameter int PULSE_W     = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic [NUM_IF-1:0] done_in,
    input  logic [NUM_IF-1:0] cal_pass_in,
    input  logic [NUM_IF-1:0] cal_fail_in,
    output logic              req_out,
    output logic              busy,
    output logic              complete,
    output logic              drop_flag,
    output logic              timeout_err,
    output logic              cal_ok,
    output logic              cal_bad
);
    localparam int SYNC_STAGES = 2;

    logic [NUM_IF-1:0] done_s, pass_s, fail_s;
    logic              all_ready, fire, pulse_last, wait_fall, expired;

    memif_rr_sync #(.WIDTH(NUM_IF), .STAGES(SYNC_STAGES)) i_sync_done (
        .clk(clk), .rst_n(rst_n), .async_in(done_in), .sync_out(done_s));
    memif_rr_sync #(.WIDTH(NUM_IF), .STAGES(SYNC_STAGES)) i_sync_pass (
        .clk(clk), .rst_n(rst_n), .async_in(cal_pass_in), .sync_out(pass_s));
    memif_rr_sync #(.WIDTH(NUM_IF), .STAGES(SYNC_STAGES)) i_sync_fail (
        .clk(clk), .rst_n(rst_n), .async_in(cal_fail_in), .sync_out(fail_s));

    assign all_ready = &done_s;

    memif_rr_seq i_seq (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .all_ready(all_ready),
        .pulse_last(pulse_last), .expired(expired), .fire(fire),
        .wait_fall(wait_fall), .busy(busy), .complete(complete),
        .drop_flag(drop_flag), .timeout_err(timeout_err));

    memif_rr_pulse #(.PULSE_W(PULSE_W)) i_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire), .req(req_out), .last(pulse_last));

    memif_rr_timeout #(.LIMIT(TIMEOUT_CYC)) i_timeout (
        .clk(clk), .rst_n(rst_n), .run(wait_fall), .expired(expired));

    // Calibration outcome comes only from the status inputs, gated by completion.
    assign cal_ok  = complete && (&pass_s) && !(|fail_s);
    assign cal_bad = complete && (|fail_s);

    // R1: a request rises only after every synchronized done flag was high.
    assert_req_needs_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> $past(all_ready));
    // R2: the request is only ever driven inside a busy sequence.
    assert_req_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |-> busy);
    // R8: pass and fail reports never coexist.
    assert_cal_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_ok && cal_bad));

endmodule

// File: tb/test_memif_rst_requester.sv
// Bench: behavioural cycle model compared against the block on every clock.
module test_memif_rst_requester;
    localparam int N  = 2;
    localparam int PW = 3;
    localparam int TO = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trigger = 1'b0;
    logic [N-1:0] done_in = '1, pass_in = '1, fail_in = '0;
    logic req_out, busy, complete, drop_flag, timeout_err, cal_ok, cal_bad;
    logic req_min, busy_min, comp_min, drop_min, err_min, ok_min, bad_min;

    always #10 clk = ~clk;   // 50 MHz

    memif_rst_requester #(.NUM_IF(N), .PULSE_W(PW), .TIMEOUT_CYC(TO)) i_memif_rst_requester (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .done_in(done_in),
        .cal_pass_in(pass_in), .cal_fail_in(fail_in), .req_out(req_out),
        .busy(busy), .complete(complete), .drop_flag(drop_flag),
        .timeout_err(timeout_err), .cal_ok(cal_ok), .cal_bad(cal_bad));

    // Second copy with a width below the minimum, to see the clamp.
    memif_rst_requester #(.NUM_IF(N), .PULSE_W(1), .TIMEOUT_CYC(TO)) i_memif_rst_requester_min (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .done_in(done_in),
        .cal_pass_in(pass_in), .cal_fail_in(fail_in), .req_out(req_min),
        .busy(busy_min), .complete(comp_min), .drop_flag(drop_min),
        .timeout_err(err_min), .cal_ok(ok_min), .cal_bad(bad_min));

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // ---------------- reference model ----------------
    int m_mode = 0, m_cnt = 0, m_tcnt = 0;
    bit m_req = 0, m_comp = 0, m_drop = 0, m_err = 0;
    bit [N-1:0] d1 = '0, d2 = '0, p1 = '0, p2 = '0, f1 = '0, f2 = '0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_tcnt = 0;
            m_req = 0; m_comp = 0; m_drop = 0; m_err = 0;
            d1 = '0; d2 = '0; p1 = '0; p2 = '0; f1 = '0; f2 = '0;
        end else begin
            bit all_r;
            int old_mode;
            all_r = &d2;
            old_mode = m_mode;
            if (trigger && old_mode != 0) m_drop = 1;
            case (old_mode)
                0: if (trigger) begin m_mode = 1; m_comp = 0; end
                1: if (all_r) begin m_mode = 2; m_req = 1; m_cnt = PW - 1; end
                2: if (m_cnt == 0) begin m_req = 0; m_mode = 3; m_tcnt = 0; end
                   else m_cnt--;
                3: if (!all_r) m_mode = 4;
                   else if (m_tcnt == TO - 1) begin m_mode = 0; m_err = 1; end
                   else m_tcnt++;
                4: if (all_r) begin m_mode = 0; m_comp = 1; end
                default: m_mode = 0;
            endcase
            d2 = d1; d1 = done_in;
            p2 = p1; p1 = pass_in;
            f2 = f1; f1 = fail_in;
        end
    end

    // Compare every output on the falling edge.
    int min_run = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(req_out == m_req, "R3 req_out", req_out, m_req);
            check(busy == (m_mode != 0), "R2 busy", busy, m_mode != 0);
            check(complete == m_comp, "R4 complete", complete, m_comp);
            check(drop_flag == m_drop, "R6 drop_flag", drop_flag, m_drop);
            check(timeout_err == m_err, "R7 timeout_err", timeout_err, m_err);
            check(cal_ok == (m_comp && &p2 && !(|f2)), "R8 cal_ok", cal_ok, m_comp && &p2 && !(|f2));
            check(cal_bad == (m_comp && |f2), "R8 cal_bad", cal_bad, m_comp && |f2);
            // R3 clamp: the PULSE_W=1 copy must hold its request for 2 cycles.
            if (req_min) min_run++;
            else if (min_run != 0) begin
                check(min_run == 2, "R3 clamped width", min_run, 2);
                min_run = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trigger();
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        tick(3);
        // R9: outputs are clear while in reset.
        check({req_out, busy, complete, drop_flag, timeout_err, cal_ok, cal_bad} == 7'd0,
              "R9 reset state", {req_out, busy, complete, drop_flag, timeout_err, cal_ok, cal_bad}, 0);
        rst_n = 1'b1;
        tick(4);

        // Normal sequence, both interfaces fall and rise together.
        pulse_trigger();
        check(busy == 1'b1, "R2 busy after trigger", busy, 1);
        tick(6);
        done_in = 2'b00; tick(5);
        done_in = 2'b11; tick(5);
        check(complete == 1'b1, "R4 complete after rise", complete, 1);
        check(cal_ok == 1'b1, "R8 cal_ok all pass", cal_ok, 1);

        // R1/R5: one interface not ready blocks the request; release timing.
        done_in = 2'b01; tick(4);
        pulse_trigger();
        check(complete == 1'b0, "R10 complete cleared by trigger", complete, 0);
        tick(8);
        check(req_out == 1'b0, "R1 held while one not done", req_out, 0);
        done_in = 2'b11;
        @(posedge clk); @(posedge clk); #1;
        check(req_out == 1'b0, "R5 two edges not yet visible", req_out, 0);
        @(posedge clk); #1;
        check(req_out == 1'b1, "R5 R1 request on third edge", req_out, 1);
        tick(2);
        // R6: extra trigger while busy is dropped.
        pulse_trigger();
        check(drop_flag == 1'b1, "R6 drop recorded", drop_flag, 1);
        // Only one interface falls: still counts as started.
        tick(3);
        done_in = 2'b10; fail_in = 2'b01; pass_in = 2'b10; tick(5);
        done_in = 2'b11; tick(6);
        check(cal_bad == 1'b1, "R8 cal_bad on fail input", cal_bad, 1);
        check(cal_ok == 1'b0, "R8 cal_ok low on fail", cal_ok, 0);

        // R7: done never falls -> timeout.
        fail_in = 2'b00; pass_in = 2'b00;
        pulse_trigger();
        tick(TO + 12);
        check(timeout_err == 1'b1, "R7 timeout raised", timeout_err, 1);
        check(complete == 1'b0, "R7 no completion", complete, 0);
        check(busy == 1'b0, "R7 busy released", busy, 0);

        // R8: completion without pass status gives neither report.
        pulse_trigger();
        tick(7);
        done_in = 2'b00; tick(4);
        done_in = 2'b11; tick(5);
        check(complete == 1'b1 && cal_ok == 1'b0 && cal_bad == 1'b0,
              "R8 done alone is not success", {complete, cal_ok, cal_bad}, 3'b100);
        check(drop_flag == 1'b1, "R6 drop still sticky", drop_flag, 1);

        tick(3);
        finish_up();
    end

endmodule